// File: doc/BRIEF.md
# Motor Stall Protection Supervisor

This block watches a three-phase brushless motor for a stalled rotor. While the motor is commanded to run, every change of the three-bit Hall code proves that the rotor still turns. If no change arrives within a programmable number of clock cycles, the block latches a stall fault. The fault asserts an inhibit output that switches off all high-side drivers. The timing capacitor of an analog design is replaced here by a clock-driven counter.

The latch can be cleared in four ways, and they behave differently. A stop command and an undervoltage flag clear it and keep the counter at zero for as long as they stay asserted. An edge on the direction input clears it for one cycle, and counting then resumes at once. A zero-duty condition on the PWM input clears the latch and holds the counter while it lasts. A thermal flag does not clear anything: it freezes the count where it is.

The same block finds zero duty by timing how long the active-low PWM input stays high. It drives a Hall-bias enable that switches off the Hall sensor supply in stop mode and while zero duty is present.

Top module: `stall_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls with `stop_req` high, `stall_fault` is 0, `hall_bias_en` is 0 and `hs_inhibit` is 1.
- R2: The stall counter advances on each clock edge only while `stop_req`, `uv_flag`, `ot_flag` and zero duty are all inactive. `stall_fault` rises on the STALL_CYC-th such edge counted from a cleared counter.
- R3: A change of `hall` relative to the value sampled at the previous edge clears the counter on that edge. `stall_fault` then rises on the STALL_CYC-th following running edge.
- R4: `hs_inhibit` is 1 whenever `stall_fault`, `stop_req`, `uv_flag` or `ot_flag` is 1, and 0 otherwise.
- R5: `stop_req` high clears `stall_fault` on the next edge and keeps the counter at zero while high. `hall_bias_en` is 0 while `stop_req` is 1.
- R6: Any change of `dir_sel` between two edges clears `stall_fault` and the counter on that edge. Counting resumes on the following edge.
- R7: Zero duty is declared on the ZD_CYC-th consecutive edge at which `pwm_in` is 1. Any edge with `pwm_in` at 0 withdraws it. `hall_bias_en` is 0 while zero duty is declared.
- R8: Declared zero duty clears `stall_fault` on the next edge and holds the counter at zero until it is withdrawn.
- R9: `uv_flag` high clears `stall_fault` on the next edge and holds the counter at zero while high.
- R10: `ot_flag` high freezes the counter without clearing it. No fault can be set while it is high, and the count continues from the frozen value afterwards.
- R11: Once set, `stall_fault` stays set through Hall changes until one of the release conditions of R5, R6, R8 or R9 occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall | input | 3 | Hall sensor code |
| stop_req | input | 1 | 1 = stop (brake), 0 = run |
| dir_sel | input | 1 | Rotation direction select |
| pwm_in | input | 1 | Speed PWM, 0 = drive on, 1 = drive off |
| uv_flag | input | 1 | Undervoltage detected |
| ot_flag | input | 1 | Overtemperature detected |
| stall_fault | output | 1 | Latched stall fault |
| hs_inhibit | output | 1 | Switch off all high-side drivers |
| hall_bias_en | output | 1 | Hall sensor supply enable |

## Verification
If the stall counter holds a wrong value, the rise of `stall_fault` moves away from its computed edge. The bench catches this on the first timeout after the error, within STALL_CYC cycles. It sweeps the Hall-change point across every offset of the window, so an off-by-one in restart or expiry shows up on the same run. If a release path or the thermal freeze is broken, the fault is either not cleared one edge after the release, or it appears at a shifted edge after the thermal flag drops. A wrong zero-duty count shows up as `hall_bias_en` falling one edge early or late.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

    // What kind of stall-latch release is active this cycle
    typedef enum logic [1:0] {
        REL_NONE   = 2'd0,  // no release
        REL_PULSE  = 2'd1,  // one-cycle release, counting resumes
        REL_HOLD   = 2'd2   // release held while the source lasts
    } rel_kind_t;

    typedef struct packed {
        logic      run;     // counter may advance
        rel_kind_t rel;     // release classification
    } stall_ctl_t;

    function automatic int cnt_bits(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

    function automatic stall_ctl_t classify(input logic stop,
                                            input logic uv,
                                            input logic zero,
                                            input logic dir_edge,
                                            input logic hot);
        stall_ctl_t c;
        if (stop || uv || zero)
            c.rel = REL_HOLD;
        else if (dir_edge)
            c.rel = REL_PULSE;
        else
            c.rel = REL_NONE;
        c.run = !(stop || uv || zero || hot);
        return c;
    endfunction

endpackage

// File: rtl/sg_edge_watch.sv
module sg_edge_watch #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic         changed
);
    logic [W-1:0] sig_q;

    always_ff @(posedge clk) begin
        sig_q <= sig;   // reset also takes the current value as reference
    end

    assign changed = !rst && (sig != sig_q);
endmodule

// File: rtl/sg_zero_duty.sv
module sg_zero_duty #(
    parameter int ZD_CYC = 400_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    output logic zero_duty
);
    import stall_guard_pkg::*;
    localparam int ZW = cnt_bits(ZD_CYC);
    localparam logic [ZW-1:0] ZLAST = ZW'(ZD_CYC - 1);

    logic [ZW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt    <= '0;
            zero_duty <= 1'b0;
        end else if (!pwm_in) begin
            hi_cnt    <= '0;
            zero_duty <= 1'b0;
        end else if (!zero_duty) begin
            if (hi_cnt == ZLAST) begin
                zero_duty <= 1'b1;
                hi_cnt    <= '0;
            end else begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sg_stall_timer.sv
module sg_stall_timer #(
    parameter int STALL_CYC = 100_000_000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  stall_guard_pkg::stall_ctl_t ctl,
    input  logic                        restart,
    output logic                        fault
);
    import stall_guard_pkg::*;
    localparam int SW = cnt_bits(STALL_CYC);
    localparam logic [SW-1:0] SLAST = SW'(STALL_CYC - 1);

    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (ctl.rel != REL_NONE) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (restart) begin
            cnt <= '0;
        end else if (ctl.run && !fault) begin
            if (cnt == SLAST) begin
                fault <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
    parameter int STALL_CYC = 100_000_000,
    parameter int ZD_CYC    = 400_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall,
    input  logic       stop_req,
    input  logic       dir_sel,
    input  logic       pwm_in,
    input  logic       uv_flag,
    input  logic       ot_flag,
    output logic       stall_fault,
    output logic       hs_inhibit,
    output logic       hall_bias_en
);
    import stall_guard_pkg::*;

    logic       hall_moved;
    logic       dir_flip;
    logic       zero_duty;
    stall_ctl_t ctl;

    sg_edge_watch #(.W(3)) u_hall_watch (
        .clk(clk), .rst(rst), .sig(hall), .changed(hall_moved)
    );

    sg_edge_watch #(.W(1)) u_dir_watch (
        .clk(clk), .rst(rst), .sig(dir_sel), .changed(dir_flip)
    );

    sg_zero_duty #(.ZD_CYC(ZD_CYC)) u_zero (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .zero_duty(zero_duty)
    );

    assign ctl = classify(stop_req, uv_flag, zero_duty, dir_flip, ot_flag);

    sg_stall_timer #(.STALL_CYC(STALL_CYC)) u_timer (
        .clk(clk), .rst(rst), .ctl(ctl), .restart(hall_moved), .fault(stall_fault)
    );

    assign hs_inhibit   = stall_fault || stop_req || uv_flag || ot_flag;
    assign hall_bias_en = !rst && !stop_req && !zero_duty;
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] hall,
    input logic       stop_req,
    input logic       dir_sel,
    input logic       pwm_in,
    input logic       uv_flag,
    input logic       ot_flag,
    input logic       stall_fault,
    input logic       hs_inhibit,
    input logic       hall_bias_en
);
    // R2 / R10: a fault only appears after a running edge
    a_r10_no_fault_when_frozen: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_fault) |-> $past(!ot_flag && !uv_flag && !stop_req));

    // R5: stop releases and turns bias off
    a_r5_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stall_fault);
    a_r5_bias_off_in_stop: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> !hall_bias_en);

    // R9: undervoltage releases
    a_r9_uv_releases: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> !stall_fault);

    // R6: direction change releases
    a_r6_dir_releases: assert property (@(posedge clk) disable iff (rst)
        (dir_sel != $past(dir_sel)) |=> !stall_fault);

    // R4: fault always inhibits the high side
    a_r4_fault_inhibits: assert property (@(posedge clk) disable iff (rst)
        stall_fault |-> hs_inhibit);

    // R7: a low PWM level withdraws zero duty at once
    a_r7_low_clears_zero: assert property (@(posedge clk) disable iff (rst)
        !pwm_in |=> (hall_bias_en == !stop_req));
endmodule

bind stall_guard sg_checker u_chk (
    .clk(clk), .rst(rst), .hall(hall), .stop_req(stop_req), .dir_sel(dir_sel),
    .pwm_in(pwm_in), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .stall_fault(stall_fault), .hs_inhibit(hs_inhibit), .hall_bias_en(hall_bias_en)
);

// File: tb/sim_stall_guard.sv
module sim_stall_guard;
    localparam int N = 20;  // stall window
    localparam int Z = 8;   // zero-duty window

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall = 3'b001;
    logic       stop_req = 1'b1;
    logic       dir_sel = 1'b0;
    logic       pwm_in = 1'b0;
    logic       uv_flag = 1'b0;
    logic       ot_flag = 1'b0;
    logic       stall_fault, hs_inhibit, hall_bias_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stall_guard #(.STALL_CYC(N), .ZD_CYC(Z)) u0 (
        .clk(clk), .rst(rst), .hall(hall), .stop_req(stop_req), .dir_sel(dir_sel),
        .pwm_in(pwm_in), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .stall_fault(stall_fault), .hs_inhibit(hs_inhibit), .hall_bias_en(hall_bias_en)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] next_hall(input logic [2:0] h);
        case (h)
            3'b001: return 3'b011;
            3'b011: return 3'b010;
            3'b010: return 3'b110;
            3'b110: return 3'b100;
            3'b100: return 3'b101;
            default: return 3'b001;
        endcase
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        chk("R1 fault in reset", stall_fault, 1'b0);
        chk("R1 bias in reset", hall_bias_en, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R1 fault", stall_fault, 1'b0);
        chk("R1 bias", hall_bias_en, 1'b0);
        chk("R1 inhibit", hs_inhibit, 1'b1);

        // R2: start, no Hall activity
        stop_req = 1'b0;
        step(N - 1);
        chk("R2 before expiry", stall_fault, 1'b0);
        chk("R4 inhibit low while running", hs_inhibit, 1'b0);
        chk("R5 bias on when started", hall_bias_en, 1'b1);
        step(1);
        chk("R2 expiry", stall_fault, 1'b1);
        chk("R4 inhibit on fault", hs_inhibit, 1'b1);

        // R11: Hall change does not clear the latch
        hall = next_hall(hall);
        step(2);
        chk("R11 latched", stall_fault, 1'b1);

        // R6: direction flip releases, counting resumes
        dir_sel = ~dir_sel;
        step(1);
        chk("R6 release", stall_fault, 1'b0);
        step(N - 1);
        chk("R6 resume before expiry", stall_fault, 1'b0);
        step(1);
        chk("R6 resume expiry", stall_fault, 1'b1);

        // R3: sweep Hall-change offset across the window
        for (int k = 1; k < N; k++) begin
            dir_sel = ~dir_sel;
            step(1);
            step(k);
            chk("R3 before change", stall_fault, 1'b0);
            hall = next_hall(hall);
            step(N);
            chk("R3 restart before expiry", stall_fault, 1'b0);
            step(1);
            chk("R3 restart expiry", stall_fault, 1'b1);
        end

        // R7 / R8: zero duty
        pwm_in = 1'b1;
        step(Z - 1);
        chk("R7 bias before zero duty", hall_bias_en, 1'b1);
        step(1);
        chk("R7 zero duty bias off", hall_bias_en, 1'b0);
        step(1);
        chk("R8 zero duty release", stall_fault, 1'b0);
        step(3 * N);
        chk("R8 counter held", stall_fault, 1'b0);
        pwm_in = 1'b0;
        step(1);
        chk("R7 low withdraws", hall_bias_en, 1'b1);
        step(N - 1);
        chk("R8 resume before expiry", stall_fault, 1'b0);
        step(1);
        chk("R8 resume expiry", stall_fault, 1'b1);

        // R7: interrupted high period does not declare zero duty
        dir_sel = ~dir_sel;
        step(1);
        pwm_in = 1'b1;
        step(Z - 1);
        pwm_in = 1'b0;
        step(1);
        pwm_in = 1'b1;
        step(Z - 1);
        chk("R7 interrupted high", hall_bias_en, 1'b1);
        pwm_in = 1'b0;
        step(1);

        // R10: thermal freeze
        dir_sel = ~dir_sel;
        step(1);
        step(5);
        ot_flag = 1'b1;
        #1;
        chk("R4 inhibit on thermal", hs_inhibit, 1'b1);
        step(50);
        chk("R10 no fault while hot", stall_fault, 1'b0);
        ot_flag = 1'b0;
        step(N - 6);
        chk("R10 frozen count kept", stall_fault, 1'b0);
        step(1);
        chk("R10 expiry from frozen count", stall_fault, 1'b1);

        // R9: undervoltage
        uv_flag = 1'b1;
        #1;
        chk("R4 inhibit on undervoltage", hs_inhibit, 1'b1);
        step(1);
        chk("R9 release", stall_fault, 1'b0);
        step(3 * N);
        chk("R9 held", stall_fault, 1'b0);
        uv_flag = 1'b0;
        step(N - 1);
        chk("R9 cleared count", stall_fault, 1'b0);
        step(1);
        chk("R9 expiry after recovery", stall_fault, 1'b1);

        // R5: stop
        stop_req = 1'b1;
        step(1);
        chk("R5 release", stall_fault, 1'b0);
        chk("R5 bias off", hall_bias_en, 1'b0);
        chk("R5 inhibit", hs_inhibit, 1'b1);
        step(3 * N);
        chk("R5 held", stall_fault, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule